// File: doc/BRIEF.md
# Six-Bit Character String Engine

This block runs string operations over 6-bit characters packed ten to a 60-bit word. Character position 0 is the most significant character of a word. A single start request carries a descriptor word, an operation code, a collating-table base and a relocation/field-length pair. The engine then walks both strings one character at a time through a word-wide memory port. It finishes with a one-cycle done strobe, a 60-bit value for the X0 register and an address-error flag.

Two of the four operations are moves. A move copies a run of characters from a source string to a destination string. Each character is read-modified-written into its word, so the neighbouring characters in that word are kept. One move form takes its descriptor straight from the request. The other form fetches the descriptor from memory.

The other two operations compare two strings. The result is the number of characters still remaining at the first mismatch, counting the mismatching one. When the first string holds the smaller character, the result is the ones complement of that count. The collated compare translates only a pair of characters that differ, using a table of 6-bit entries packed eight per word. If the two translations are equal, the compare carries on.

Top module: `char_string_engine`

## Requirements
- R1: Character position p of a word occupies bits (9-p)*6+5 down to (9-p)*6, so position 0 is bits 59..54 and position 9 is bits 5..0.
- R2: op_sel selects the operation: 0 is a move with the descriptor fetched from memory, 1 is a move with the descriptor in desc_word, 2 is a collated compare and 3 is a plain compare. The descriptor holds the source word address in bits 47..30, the destination word address in bits 17..0, the source position in bits 25..22 and the destination position in bits 21..18. The length is {upper, bits 29..26}. Its upper part is bits 50..48 when the descriptor comes from desc_word and bits 56..48 when it comes from memory. For op 0, bits 47..30 of desc_word give the address of the descriptor word.
- R3: If the source or destination position exceeds 9, the operation finishes with addr_err=1 and result 0, and no character is written.
- R4: After each character both positions step by one. A position that passes 9 wraps to 0 and its word address steps by one.
- R5: A move replaces only the destination character in each destination word and finishes with result 0.
- R6: A compare stops at the first unequal pair. The result is the number of characters remaining, counting that pair, zero-extended to 60 bits. It is the 60-bit ones complement of that count when the first-string character is the smaller one.
- R7: A compare in which all characters match, or any operation of length 0, finishes with result 0 and addr_err=0.
- R8: In a collated compare, a differing character c is replaced by the entry at position c[2:0] of table word coll_base+c[5:3], in both strings. Equal translations continue the compare. Characters that are equal as read are not translated.
- R9: Every access uses the memory address reloc_base plus a relative address. An access whose relative address is at or above field_len is not issued and ends the operation with addr_err=1. Characters already moved stay written.
- R10: done is high for exactly one cycle per operation. result and addr_err are valid in that cycle and are held until the next completion.
- R11: Read data is taken one cycle after mem_rd. mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_sel | input | 2 | Operation code (R2) |
| desc_word | input | 60 | Inline descriptor, or pointer word for op 0 |
| coll_base | input | 18 | Relative word address of the collating table |
| reloc_base | input | 18 | Relocation added to every relative address |
| field_len | input | 18 | Exclusive limit on relative addresses |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 18 | Absolute word address |
| mem_wdata | output | 60 | Write data |
| mem_rdata | input | 60 | Read data, one cycle after mem_rd |
| result | output | 60 | Value for X0 |
| done | output | 1 | One-cycle completion strobe |
| addr_err | output | 1 | Address error of the last operation |

## Verification
Two events can land in the same advance step: a position wrapping into the next word, and the mismatch on the character that follows the wrap. The bench provokes this by comparing strings that start at position 8 and differ on the fourth character. The plain form must report 3. The collated form must translate that pair to equal values and report 0. A second pairing is a move whose destination crosses the field limit part-way through. Memory is checked afterwards: the characters before the limit must be written, the word at the limit must be untouched, and the error flag must be raised in the same done cycle.

// File: rtl/cse_pkg.sv
package cse_pkg;

  typedef enum logic [1:0] {
    OP_MOVE_MEM = 2'd0,
    OP_MOVE_INL = 2'd1,
    OP_CMP_TBL  = 2'd2,
    OP_CMP_RAW  = 2'd3
  } cse_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DRD, S_DCAP, S_CHK, S_RSRC, S_RDST,
    S_CAPD, S_WR, S_TA, S_TB, S_TC, S_ADV
  } cse_state_e;

  // descriptor field low bits
  localparam int F_K1_LO = 30;
  localparam int F_K2_LO = 0;
  localparam int F_C1_LO = 22;
  localparam int F_C2_LO = 18;
  localparam int F_LN_LO = 26;
  localparam int F_LH_LO = 48;

endpackage

// File: rtl/cse_char_pick.sv
module cse_char_pick #(
  parameter int CW  = 6,
  parameter int CPW = 10,
  localparam int WW = CW * CPW,
  localparam int PW = $clog2(CPW)
) (
  input  logic [WW-1:0] word,
  input  logic [PW-1:0] pos,
  output logic [CW-1:0] ch
);
  logic [CW-1:0] lanes [CPW];

  for (genvar g = 0; g < CPW; g++) begin : g_lane
    assign lanes[g] = word[(CPW-1-g)*CW +: CW];
  end

  always_comb begin
    ch = '0;
    for (int i = 0; i < CPW; i++) begin
      if (pos == PW'(i)) ch = lanes[i];
    end
  end
endmodule

// File: rtl/cse_char_merge.sv
module cse_char_merge #(
  parameter int CW  = 6,
  parameter int CPW = 10,
  localparam int WW = CW * CPW,
  localparam int PW = $clog2(CPW)
) (
  input  logic [WW-1:0] word_in,
  input  logic [PW-1:0] pos,
  input  logic [CW-1:0] ch,
  output logic [WW-1:0] word_out
);
  for (genvar g = 0; g < CPW; g++) begin : g_lane
    assign word_out[(CPW-1-g)*CW +: CW] =
      (pos == PW'(g)) ? ch : word_in[(CPW-1-g)*CW +: CW];
  end
endmodule

// File: rtl/cse_pos_ctr.sv
module cse_pos_ctr #(
  parameter int AW  = 18,
  parameter int CPW = 10,
  localparam int PW = $clog2(CPW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ld_addr,
  input  logic [PW-1:0] ld_pos,
  output logic [AW-1:0] addr,
  output logic [PW-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      pos  <= '0;
    end else if (load) begin
      addr <= ld_addr;
      pos  <= ld_pos;
    end else if (step) begin
      if (pos >= PW'(CPW-1)) begin
        pos  <= '0;
        addr <= addr + AW'(1);
      end else begin
        pos <= pos + PW'(1);
      end
    end
  end
endmodule

// File: rtl/char_string_engine.sv
module char_string_engine
  import cse_pkg::*;
#(
  parameter int AW           = 18,
  parameter int CW           = 6,
  parameter int CPW          = 10,
  parameter int LEN_LO_W     = 4,
  parameter int LEN_HI_INL_W = 3,
  parameter int LEN_HI_MEM_W = 9,
  localparam int WW = CW * CPW,
  localparam int PW = $clog2(CPW),
  localparam int LW = LEN_LO_W + LEN_HI_MEM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op_sel,
  input  logic [WW-1:0] desc_word,
  input  logic [AW-1:0] coll_base,
  input  logic [AW-1:0] reloc_base,
  input  logic [AW-1:0] field_len,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [WW-1:0] mem_wdata,
  input  logic [WW-1:0] mem_rdata,
  output logic [WW-1:0] result,
  output logic          done,
  output logic          addr_err
);
  localparam int TIW = CW / 2;

  cse_state_e    st;
  cse_op_e       op_q;
  logic [AW-1:0] reloc_q, fl_q, coll_q, ptr_q;
  logic [LW-1:0] rem;
  logic [CW-1:0] ch1, ch2, ch1t;
  logic [WW-1:0] wbuf;

  logic [WW-1:0] fw;
  logic [LW-1:0] len_inl, len_mem;
  logic          ld_ctr, step_ctr;
  logic [AW-1:0] src_addr, dst_addr;
  logic [PW-1:0] src_pos, dst_pos;
  logic [AW-1:0] req_rel;
  logic          acc_rd, req_ok, is_move, c_bad;
  logic [PW-1:0] pk_pos;
  logic [CW-1:0] pk_ch;
  logic [WW-1:0] merged;
  logic [WW-1:0] rem_w;

  // field source: request word when idle, fetched descriptor otherwise
  assign fw      = (st == S_DCAP) ? mem_rdata : desc_word;
  assign len_inl = LW'({fw[F_LH_LO +: LEN_HI_INL_W], fw[F_LN_LO +: LEN_LO_W]});
  assign len_mem = LW'({fw[F_LH_LO +: LEN_HI_MEM_W], fw[F_LN_LO +: LEN_LO_W]});
  assign ld_ctr  = (st == S_DCAP) ||
                   (st == S_IDLE && start && op_sel != OP_MOVE_MEM);
  assign step_ctr = (st == S_ADV);
  assign is_move  = (op_q == OP_MOVE_MEM) || (op_q == OP_MOVE_INL);
  assign c_bad    = (src_pos > PW'(CPW-1)) || (dst_pos > PW'(CPW-1));
  assign rem_w    = {{(WW-LW){1'b0}}, rem};

  cse_pos_ctr #(.AW(AW), .CPW(CPW)) u_src (
    .clk(clk), .rst(rst), .load(ld_ctr), .step(step_ctr),
    .ld_addr(fw[F_K1_LO +: AW]), .ld_pos(fw[F_C1_LO +: PW]),
    .addr(src_addr), .pos(src_pos)
  );

  cse_pos_ctr #(.AW(AW), .CPW(CPW)) u_dst (
    .clk(clk), .rst(rst), .load(ld_ctr), .step(step_ctr),
    .ld_addr(fw[F_K2_LO +: AW]), .ld_pos(fw[F_C2_LO +: PW]),
    .addr(dst_addr), .pos(dst_pos)
  );

  // relative address of the access requested in this state
  always_comb begin
    acc_rd  = 1'b0;
    req_rel = '0;
    unique case (st)
      S_DRD:  begin acc_rd = 1'b1; req_rel = ptr_q; end
      S_RSRC: begin acc_rd = 1'b1; req_rel = src_addr; end
      S_RDST: begin acc_rd = 1'b1; req_rel = dst_addr; end
      S_WR:   req_rel = dst_addr;
      S_TA:   begin acc_rd = 1'b1; req_rel = coll_q + AW'(ch1[CW-1 -: TIW]); end
      S_TB:   begin acc_rd = 1'b1; req_rel = coll_q + AW'(ch2[CW-1 -: TIW]); end
      default: ;
    endcase
  end

  assign req_ok    = req_rel < fl_q;
  assign mem_rd    = acc_rd && req_ok;
  assign mem_wr    = (st == S_WR) && req_ok;
  assign mem_addr  = reloc_q + req_rel;
  assign mem_wdata = merged;

  // character select for whichever word is arriving this cycle
  always_comb begin
    unique case (st)
      S_CAPD:  pk_pos = dst_pos;
      S_TB:    pk_pos = PW'(ch1[TIW-1:0]);
      S_TC:    pk_pos = PW'(ch2[TIW-1:0]);
      default: pk_pos = src_pos;
    endcase
  end

  cse_char_pick #(.CW(CW), .CPW(CPW)) u_pick (
    .word(mem_rdata), .pos(pk_pos), .ch(pk_ch)
  );

  cse_char_merge #(.CW(CW), .CPW(CPW)) u_merge (
    .word_in(wbuf), .pos(dst_pos), .ch(ch1), .word_out(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      op_q     <= OP_MOVE_MEM;
      reloc_q  <= '0;
      fl_q     <= '0;
      coll_q   <= '0;
      ptr_q    <= '0;
      rem      <= '0;
      ch1      <= '0;
      ch2      <= '0;
      ch1t     <= '0;
      wbuf     <= '0;
      result   <= '0;
      done     <= 1'b0;
      addr_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          op_q    <= cse_op_e'(op_sel);
          reloc_q <= reloc_base;
          fl_q    <= field_len;
          coll_q  <= coll_base;
          ptr_q   <= desc_word[F_K1_LO +: AW];
          rem     <= len_inl;
          st      <= (op_sel == OP_MOVE_MEM) ? S_DRD : S_CHK;
        end
        S_DRD:
          if (!req_ok) begin
            done <= 1'b1; addr_err <= 1'b1; result <= '0; st <= S_IDLE;
          end else st <= S_DCAP;
        S_DCAP: begin
          rem <= len_mem;
          st  <= S_CHK;
        end
        S_CHK:
          if (c_bad) begin
            done <= 1'b1; addr_err <= 1'b1; result <= '0; st <= S_IDLE;
          end else if (rem == '0) begin
            done <= 1'b1; addr_err <= 1'b0; result <= '0; st <= S_IDLE;
          end else st <= S_RSRC;
        S_RSRC:
          if (!req_ok) begin
            done <= 1'b1; addr_err <= 1'b1; result <= '0; st <= S_IDLE;
          end else st <= S_RDST;
        S_RDST: begin
          ch1 <= pk_ch;
          if (!req_ok) begin
            done <= 1'b1; addr_err <= 1'b1; result <= '0; st <= S_IDLE;
          end else st <= S_CAPD;
        end
        S_CAPD:
          if (is_move) begin
            wbuf <= mem_rdata;
            st   <= S_WR;
          end else begin
            ch2 <= pk_ch;
            if (pk_ch == ch1) st <= S_ADV;
            else if (op_q == OP_CMP_TBL) st <= S_TA;
            else begin
              done     <= 1'b1;
              addr_err <= 1'b0;
              result   <= (ch1 < pk_ch) ? ~rem_w : rem_w;
              st       <= S_IDLE;
            end
          end
        S_WR: st <= S_ADV;
        S_TA:
          if (!req_ok) begin
            done <= 1'b1; addr_err <= 1'b1; result <= '0; st <= S_IDLE;
          end else st <= S_TB;
        S_TB: begin
          ch1t <= pk_ch;
          if (!req_ok) begin
            done <= 1'b1; addr_err <= 1'b1; result <= '0; st <= S_IDLE;
          end else st <= S_TC;
        end
        S_TC:
          if (pk_ch == ch1t) st <= S_ADV;
          else begin
            done     <= 1'b1;
            addr_err <= 1'b0;
            result   <= (ch1t < pk_ch) ? ~rem_w : rem_w;
            st       <= S_IDLE;
          end
        S_ADV: begin
          rem <= rem - LW'(1);
          if (rem == LW'(1)) begin
            done <= 1'b1; addr_err <= 1'b0; result <= '0; st <= S_IDLE;
          end else st <= S_RSRC;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cse_checker.sv
module cse_checker #(
  parameter int AW = 18,
  parameter int WW = 60
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] reloc_q,
  input logic [AW-1:0] fl_q,
  input logic [1:0]    op_q,
  input logic [WW-1:0] result,
  input logic          done,
  input logic          addr_err
);
  // R11
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  fl_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> ((mem_addr - reloc_q) < fl_q));

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && addr_err) |-> (result == '0));

  // R5
  wr_only_move_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (op_q[1] == 1'b0));

  // R5
  move_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_q[1] == 1'b0) |-> (result == '0));
endmodule

bind char_string_engine cse_checker #(.AW(AW), .WW(WW)) u_cse_checker (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .reloc_q(reloc_q), .fl_q(fl_q), .op_q(op_q),
  .result(result), .done(done), .addr_err(addr_err)
);

// File: tb/test_char_string_engine.sv
module test_char_string_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [59:0] desc_word = '0;
  logic [17:0] coll_base = 18'd40;
  logic [17:0] reloc_base = '0;
  logic [17:0] field_len = 18'd64;
  logic        mem_rd, mem_wr, done, addr_err;
  logic [17:0] mem_addr;
  logic [59:0] mem_wdata, result;
  logic [59:0] mem_rdata = '0;
  logic [59:0] mem [64];

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  char_string_engine i_char_string_engine (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
    .desc_word(desc_word), .coll_base(coll_base), .reloc_base(reloc_base),
    .field_len(field_len), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .result(result), .done(done), .addr_err(addr_err)
  );

  // word memory, one-cycle read latency (R11)
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
  end

  // R1 char layout, R2 descriptor layout
  function automatic logic [5:0] ch_of(input logic [59:0] w, input int p);
    return w[(9-p)*6 +: 6];
  endfunction

  function automatic logic [59:0] mk(input int k1, input int c1, input int k2,
                                     input int c2, input int lo, input int hi);
    logic [59:0] w;
    w = '0;
    w[47:30] = 18'(k1);
    w[17:0]  = 18'(k2);
    w[25:22] = 4'(c1);
    w[21:18] = 4'(c2);
    w[29:26] = 4'(lo);
    w[56:48] = 9'(hi);
    return w;
  endfunction

  function automatic logic [59:0] pat_word(input int i);
    logic [59:0] w;
    w = '0;
    for (int p = 0; p < 10; p++) w[(9-p)*6 +: 6] = 6'((i*10 + p) % 64);
    return w;
  endfunction

  typedef struct packed {
    logic [1:0]  op;
    logic [59:0] dw;
    logic [17:0] rl;
    logic [17:0] fl;
    logic [59:0] er;
    logic        ee;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd3, mk(0,0,0,0,5,0),   18'd0,  18'd64, 60'd0,                 1'b0, 8'd7},  // R7 all match
    '{2'd3, mk(0,0,0,1,4,0),   18'd0,  18'd64, 60'hFFFFFFFFFFFFFFB,   1'b0, 8'd6},  // R6 first smaller
    '{2'd3, mk(0,3,0,1,6,0),   18'd0,  18'd64, 60'd6,                 1'b0, 8'd6},  // R6 first larger
    '{2'd3, mk(0,8,30,8,6,0),  18'd0,  18'd64, 60'd3,                 1'b0, 8'd4},  // R4 wrap then mismatch
    '{2'd2, mk(0,8,30,8,6,0),  18'd0,  18'd64, 60'd0,                 1'b0, 8'd8},  // R8 equal translation
    '{2'd2, mk(0,0,0,3,2,0),   18'd0,  18'd64, 60'd2,                 1'b0, 8'd8},  // R8 order reversed
    '{2'd3, mk(0,0,0,3,2,0),   18'd0,  18'd64, 60'hFFFFFFFFFFFFFFD,   1'b0, 8'd6},  // R6 plain counterpart
    '{2'd3, mk(0,0,20,0,1,0),  18'd10, 18'd40, 60'd1,                 1'b0, 8'd9},  // R9 relocation
    '{2'd3, mk(0,10,0,0,3,0),  18'd0,  18'd64, 60'd0,                 1'b1, 8'd3},  // R3 bad source pos
    '{2'd3, mk(0,0,5,0,3,0),   18'd0,  18'd5,  60'd0,                 1'b1, 8'd9},  // R9 dst at FL
    '{2'd3, mk(0,0,0,1,0,0),   18'd0,  18'd64, 60'd0,                 1'b0, 8'd7},  // R7 zero length
    '{2'd1, mk(0,2,50,5,12,0), 18'd0,  18'd64, 60'd0,                 1'b0, 8'd5},  // R5 move
    '{2'd1, mk(1,0,52,0,1,1),  18'd0,  18'd64, 60'd0,                 1'b0, 8'd2},  // R2 length 17
    '{2'd1, mk(3,0,61,0,2,8),  18'd0,  18'd64, 60'd0,                 1'b0, 8'd2},  // R2 bit 51 ignored
    '{2'd0, mk(62,0,0,0,0,0),  18'd0,  18'd64, 60'd0,                 1'b0, 8'd2},  // R2 fetched, len 66
    '{2'd1, mk(0,0,50,11,3,0), 18'd0,  18'd64, 60'd0,                 1'b1, 8'd3},  // R3 bad dest pos
    '{2'd2, mk(0,0,0,0,3,0),   18'd0,  18'd64, 60'd0,                 1'b0, 8'd8}   // R8 raw equal
  };

  task automatic chk(input int rq, input string what,
                     input logic [59:0] act, input logic [59:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [59:0] dw,
                        input logic [17:0] rl, input logic [17:0] fl,
                        output logic [59:0] res, output logic err);
    int n;
    @(negedge clk);
    op_sel = op; desc_word = dw; reloc_base = rl; field_len = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(10, "done seen", 60'(done), 60'd1);  // R10
    res = result;
    err = addr_err;
    @(negedge clk);
    chk(10, "done one cycle", 60'(done), 60'd0);  // R10
    chk(10, "result held", result, res);  // R10
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [59:0] res;
    logic        err;
    for (int i = 0; i < 64; i++) mem[i] = pat_word(i);
    mem[30] = pat_word(0);
    mem[31] = pat_word(1);
    mem[31][(9-1)*6 +: 6] = 6'd5;
    // collating table: identity except t(0)=60, t(3)=50, t(11)=5
    mem[40] = '0;
    mem[41] = '0;
    for (int p = 0; p < 8; p++) begin
      mem[40][(9-p)*6 +: 6] = 6'(p);
      mem[41][(9-p)*6 +: 6] = 6'(8 + p);
    end
    mem[40][(9-0)*6 +: 6] = 6'd60;
    mem[40][(9-3)*6 +: 6] = 6'd50;
    mem[41][(9-3)*6 +: 6] = 6'd5;
    for (int i = 50; i < 62; i++) mem[i] = '1;
    mem[62] = mk(2,0,54,0,2,4);

    repeat (3) @(negedge clk);
    // reset state
    chk(10, "reset done", 60'(done), 60'd0);
    chk(10, "reset addr_err", 60'(addr_err), 60'd0);
    chk(11, "reset mem_rd", 60'(mem_rd), 60'd0);
    chk(11, "reset mem_wr", 60'(mem_wr), 60'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].op, VECS[i].dw, VECS[i].rl, VECS[i].fl, res, err);
      chk(int'(VECS[i].rq), $sformatf("vec %0d result", i), res, VECS[i].er);
      chk(int'(VECS[i].rq), $sformatf("vec %0d addr_err", i), 60'(err), 60'(VECS[i].ee));
    end

    // R5 / R1: partial words keep the untouched characters
    chk(5, "m50 p0 kept", 60'(ch_of(mem[50], 0)), 60'd63);
    chk(5, "m50 p4 kept", 60'(ch_of(mem[50], 4)), 60'd63);
    chk(1, "m50 p5", 60'(ch_of(mem[50], 5)), 60'd2);
    chk(4, "m51 p0 after wrap", 60'(ch_of(mem[51], 0)), 60'd7);
    chk(5, "m51 p6", 60'(ch_of(mem[51], 6)), 60'd13);
    chk(5, "m51 p7 kept", 60'(ch_of(mem[51], 7)), 60'd63);
    // R2: 3-bit upper length (17 chars)
    chk(2, "m52 p9", 60'(ch_of(mem[52], 9)), 60'd19);
    chk(2, "m53 p6", 60'(ch_of(mem[53], 6)), 60'd26);
    chk(2, "m53 p7 kept", 60'(ch_of(mem[53], 7)), 60'd63);
    // R2: inline form ignores bit 51
    chk(2, "m61 p1", 60'(ch_of(mem[61], 1)), 60'd31);
    chk(2, "m61 p2 kept", 60'(ch_of(mem[61], 2)), 60'd63);
    // R2: fetched form uses 9 upper bits (66 chars)
    chk(2, "m54 p0", 60'(ch_of(mem[54], 0)), 60'd20);
    chk(2, "m60 p5", 60'(ch_of(mem[60], 5)), 60'd21);
    chk(2, "m60 p6 kept", 60'(ch_of(mem[60], 6)), 60'd63);

    // R9: move that runs into the field limit part-way
    run_op(2'd1, mk(0,0,19,8,4,0), 18'd0, 18'd20, res, err);
    chk(9, "fl move addr_err", 60'(err), 60'd1);
    chk(9, "fl move result", res, 60'd0);
    chk(9, "m19 p7 kept", 60'(ch_of(mem[19], 7)), 60'd5);
    chk(9, "m19 p8 written", 60'(ch_of(mem[19], 8)), 60'd0);
    chk(9, "m19 p9 written", 60'(ch_of(mem[19], 9)), 60'd1);
    chk(9, "m20 untouched", mem[20], pat_word(20));

    // R3: rejected move left destination alone
    chk(3, "m50 after bad pos", 60'(ch_of(mem[50], 0)), 60'd63);

    // R10: flags held after completion while idle
    repeat (4) @(negedge clk);
    chk(10, "addr_err held", 60'(addr_err), 60'd1);

    summary();
    $finish;
  end
endmodule